// File: doc/BRIEF.md
# SCSI Target Phase Sequencer

This block is the target-side sequencer that walks a SCSI device through the information-transfer phases once the device has been selected. A controlling device model asks for each phase with a request code, a byte count and a continuation tag. The sequencer checks the request against the allowed phase order and then drives the three phase lines (message, control/data, input/output) to that phase's pattern. It then moves the requested number of bytes with a REQ/ACK handshake and reports completion together with the tag it stored when the phase began. The controller uses that tag to decide which step comes next.

The sequencer compares the live phase lines on the bus with the pattern it drives. In the data, status and message phases, any disagreement means another device has taken the bus or the initiator has gone away. The sequencer then abandons the exchange, releases every line and returns to waiting for selection. During the command phase and while idle, disagreements are ignored.

The data bus is driven only while input/output is asserted. In phases where the initiator sends, the block captures one byte each time it senses ACK. ACK passes through a parameterised synchroniser before the handshake logic uses it.

Top module: `scsi_tgt_phase_seq`

## Requirements
- R1: After reset, bsy_o, req_o, msg_o, cd_o, io_o, db_oe_o, done_o, abort_o and rx_stb_o are all low, and ptr_o is zero.
- R2: A request with code 0 (command) is accepted only while idle and with sel_i high. In the idle state, every other request, and a command request without sel_i, leaves bsy_o low.
- R3: The driven phase lines {msg_o,cd_o,io_o} are 010 for command, 000 for data-out (code 1), 001 for data-in (code 2), 011 for status (code 3) and 110 for message (code 4). When idle they are 000.
- R4: The only phase moves accepted are: command to data-out, data-in or status; either data phase to status; status to message; message to release (code 5). Any other request leaves the phase unchanged.
- R5: A request is ignored while the current phase still has bytes to move.
- R6: For each byte, req_o rises and stays high until ACK is sensed, then falls. ptr_o increments once ACK is sensed low again. req_o never rises while ACK is still high.
- R7: When ptr_o reaches the phase length, done_o pulses for one cycle with done_tag_o equal to the tag given at phase entry. The phase lines stay driven and req_o stays low.
- R8: A phase with length zero raises done_o in the cycle after entry and never raises req_o.
- R9: Entering a phase resets ptr_o to zero.
- R10: In data-out, data-in, status or message, including after the phase has completed, a bus phase pattern different from the driven one returns the block to idle. This releases all lines and pulses abort_o for one cycle. In command or idle, such a difference has no effect.
- R11: db_oe_o is high exactly when io_o is high, and db_o then equals tx_byte_i. When io_o is low, each sensed ACK captures db_i into rx_byte_o, with one rx_stb_o pulse per byte.
- R12: A release request after the message phase completes returns the block to idle with bsy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Device is being selected |
| rq_vld_i | input | 1 | Phase request strobe |
| rq_code_i | input | 3 | Requested phase: 0 cmd, 1 data-out, 2 data-in, 3 status, 4 message, 5 release |
| rq_len_i | input | LEN_W | Bytes to move in the requested phase |
| rq_tag_i | input | TAG_W | Continuation tag returned at phase end |
| bus_msg_i | input | 1 | Observed message line |
| bus_cd_i | input | 1 | Observed control/data line |
| bus_io_i | input | 1 | Observed input/output line |
| ack_i | input | 1 | Initiator acknowledge (asynchronous) |
| db_i | input | 8 | Observed data bus |
| tx_byte_i | input | 8 | Byte to drive in target-to-initiator phases |
| bsy_o | output | 1 | Target holds the bus |
| msg_o | output | 1 | Driven message line |
| cd_o | output | 1 | Driven control/data line |
| io_o | output | 1 | Driven input/output line |
| req_o | output | 1 | Byte request |
| db_o | output | 8 | Data bus drive value |
| db_oe_o | output | 1 | Data bus drive enable |
| rx_byte_o | output | 8 | Last byte received |
| rx_stb_o | output | 1 | One-cycle pulse per received byte |
| ptr_o | output | LEN_W | Bytes completed in the current phase |
| done_o | output | 1 | One-cycle phase completion pulse |
| done_tag_o | output | TAG_W | Tag of the phase that completed |
| abort_o | output | 1 | One-cycle pulse on a phase mismatch abort |

## Verification
The bench targets four failure areas. The first is request legality: a sequencer that accepted a command without selection, or allowed a skip such as command straight to message, would show the wrong phase lines. The second is the mismatch watch. Checking in the command phase would drop a healthy selection. Missing the check in a completed phase would leave the target holding a dead bus. The third is the zero-length phase: a design that entered the handshake anyway would emit a stray REQ, or would never finish. The fourth is the byte count. Counting on the ACK rise instead of the fall, or re-raising REQ while ACK is still high, shows up as a wrong REQ count or a wrong pointer at completion.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CMD  = 3'd1,
      PH_DOUT = 3'd2,
      PH_DIN  = 3'd3,
      PH_STAT = 3'd4,
      PH_MSG  = 3'd5
   } phase_e;

   localparam logic [2:0] RQ_CMD  = 3'd0;
   localparam logic [2:0] RQ_DOUT = 3'd1;
   localparam logic [2:0] RQ_DIN  = 3'd2;
   localparam logic [2:0] RQ_STAT = 3'd3;
   localparam logic [2:0] RQ_MSG  = 3'd4;
   localparam logic [2:0] RQ_REL  = 3'd5;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_REQ  = 2'd1,
      HS_REL  = 2'd2,
      HS_FIN  = 2'd3
   } hs_e;

   // line pattern {msg, cd, io} for each phase
   function automatic logic [2:0] ph_lines(phase_e p);
      case (p)
         PH_CMD:  return 3'b010;
         PH_DOUT: return 3'b000;
         PH_DIN:  return 3'b001;
         PH_STAT: return 3'b011;
         PH_MSG:  return 3'b110;
         default: return 3'b000;
      endcase
   endfunction

   function automatic phase_e rq_target(logic [2:0] c);
      case (c)
         RQ_CMD:  return PH_CMD;
         RQ_DOUT: return PH_DOUT;
         RQ_DIN:  return PH_DIN;
         RQ_STAT: return PH_STAT;
         RQ_MSG:  return PH_MSG;
         default: return PH_IDLE;
      endcase
   endfunction

   function automatic logic rq_legal(phase_e p, logic [2:0] c, logic sel);
      case (p)
         PH_IDLE: return (c == RQ_CMD) && sel;
         PH_CMD:  return (c == RQ_DOUT) || (c == RQ_DIN) || (c == RQ_STAT);
         PH_DOUT,
         PH_DIN:  return c == RQ_STAT;
         PH_STAT: return c == RQ_MSG;
         PH_MSG:  return c == RQ_REL;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/scsi_ack_sync.sv
module scsi_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_i,
   output logic ack_o
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("scsi_ack_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign ack_o = ack_i;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-1:0] << 1} | {{(STAGES-1){1'b0}}, ack_i};
      end
      assign ack_o = sh_q[STAGES-1];
   end

endmodule

// File: rtl/scsi_byte_hs.sv
module scsi_byte_hs
   import scsi_seq_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             kill_i,
   input  logic             ack_i,
   output logic             req_o,
   output logic             take_o,
   output logic [LEN_W-1:0] ptr_o,
   output logic             done_o
);

   if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
      $error("scsi_byte_hs: LEN_W must be 1..32");
   end

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   hs_e              st_q;
   logic [LEN_W-1:0] ptr_q, len_q;
   logic [LEN_W-1:0] ptr_nx;

   assign ptr_nx = ptr_q + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= HS_IDLE;
         ptr_q <= '0;
         len_q <= '0;
      end else if (kill_i) begin
         st_q  <= HS_IDLE;
         ptr_q <= '0;
      end else if (start_i) begin
         len_q <= len_i;
         ptr_q <= '0;
         st_q  <= (len_i == '0) ? HS_FIN : HS_REQ;
      end else begin
         case (st_q)
            HS_REQ: if (ack_i) st_q <= HS_REL;
            HS_REL: if (!ack_i) begin
               ptr_q <= ptr_nx;
               st_q  <= (ptr_nx == len_q) ? HS_FIN : HS_REQ;
            end
            HS_FIN:  st_q <= HS_IDLE;
            default: st_q <= HS_IDLE;
         endcase
      end
   end

   assign req_o  = (st_q == HS_REQ);
   assign take_o = (st_q == HS_REQ) && ack_i && !kill_i;
   assign done_o = (st_q == HS_FIN);
   assign ptr_o  = ptr_q;

   p_req_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i && !kill_i && !start_i) |=> !req_o);

   p_req_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_o) && !$past(start_i)) |-> !$past(ack_i));

   p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !kill_i) |=> (ptr_o == $past(ptr_o) || ptr_o == $past(ptr_o) + ONE));

   p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != HS_IDLE) |-> (ptr_q <= len_q));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !kill_i && len_i == '0) |=> (done_o && !req_o));

endmodule

// File: rtl/scsi_phase_ctl.sv
module scsi_phase_ctl
   import scsi_seq_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             rq_vld_i,
   input  logic [2:0]       rq_code_i,
   input  logic [LEN_W-1:0] rq_len_i,
   input  logic [TAG_W-1:0] rq_tag_i,
   input  logic [2:0]       bus_ph_i,
   input  logic             xfer_done_i,
   output phase_e           phase_o,
   output logic             start_o,
   output logic [LEN_W-1:0] len_o,
   output logic             kill_o,
   output logic             abort_o,
   output logic             busy_o,
   output logic [TAG_W-1:0] tag_o
);

   if (TAG_W < 1) begin : g_bad_tag
      $error("scsi_phase_ctl: TAG_W must be at least 1");
   end

   phase_e           ph_q;
   logic             busy_q, abort_q;
   logic [TAG_W-1:0] tag_q;
   logic             late, mism, accept;
   phase_e           tgt;

   // past the command phase the bus must show exactly what is driven
   assign late   = (ph_q == PH_DOUT) || (ph_q == PH_DIN) ||
                   (ph_q == PH_STAT) || (ph_q == PH_MSG);
   assign mism   = late && (bus_ph_i != ph_lines(ph_q));
   assign tgt    = rq_target(rq_code_i);
   assign accept = rq_vld_i && !busy_q && !mism && rq_legal(ph_q, rq_code_i, sel_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         busy_q  <= 1'b0;
         abort_q <= 1'b0;
         tag_q   <= '0;
      end else if (mism) begin
         ph_q    <= PH_IDLE;
         busy_q  <= 1'b0;
         abort_q <= 1'b1;
      end else begin
         abort_q <= 1'b0;
         if (xfer_done_i) busy_q <= 1'b0;
         if (accept) begin
            ph_q <= tgt;
            if (tgt != PH_IDLE) begin
               busy_q <= 1'b1;
               tag_q  <= rq_tag_i;
            end
         end
      end
   end

   assign phase_o = ph_q;
   assign start_o = accept && (tgt != PH_IDLE);
   assign len_o   = rq_len_i;
   assign kill_o  = mism || (accept && tgt == PH_IDLE);
   assign abort_o = abort_q;
   assign busy_o  = busy_q;
   assign tag_o   = tag_q;

   p_cmd_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IDLE && !sel_i) |=> (ph_q == PH_IDLE));

   p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !mism) |=> (ph_q == $past(ph_q)));

   p_mismatch_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mism |=> (ph_q == PH_IDLE && abort_q));

   p_rel_to_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rq_code_i == RQ_REL) |=> (ph_q == PH_IDLE && !busy_q));

endmodule

// File: rtl/scsi_tgt_phase_seq.sv
module scsi_tgt_phase_seq
   import scsi_seq_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int TAG_W    = 4,
   parameter int ACK_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic             rq_vld_i,
   input  logic [2:0]       rq_code_i,
   input  logic [LEN_W-1:0] rq_len_i,
   input  logic [TAG_W-1:0] rq_tag_i,
   input  logic             bus_msg_i,
   input  logic             bus_cd_i,
   input  logic             bus_io_i,
   input  logic             ack_i,
   input  logic [7:0]       db_i,
   input  logic [7:0]       tx_byte_i,
   output logic             bsy_o,
   output logic             msg_o,
   output logic             cd_o,
   output logic             io_o,
   output logic             req_o,
   output logic [7:0]       db_o,
   output logic             db_oe_o,
   output logic [7:0]       rx_byte_o,
   output logic             rx_stb_o,
   output logic [LEN_W-1:0] ptr_o,
   output logic             done_o,
   output logic [TAG_W-1:0] done_tag_o,
   output logic             abort_o
);

   phase_e           ph;
   logic             start, kill, busy, ack_s, take, hs_req;
   logic [LEN_W-1:0] len;
   logic [2:0]       lines;
   logic [7:0]       rx_q;
   logic             rx_stb_q;

   scsi_ack_sync #(.STAGES(ACK_SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .ack_i (ack_i),
      .ack_o (ack_s)
   );

   scsi_phase_ctl #(.LEN_W(LEN_W), .TAG_W(TAG_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_i       (sel_i),
      .rq_vld_i    (rq_vld_i),
      .rq_code_i   (rq_code_i),
      .rq_len_i    (rq_len_i),
      .rq_tag_i    (rq_tag_i),
      .bus_ph_i    ({bus_msg_i, bus_cd_i, bus_io_i}),
      .xfer_done_i (done_o),
      .phase_o     (ph),
      .start_o     (start),
      .len_o       (len),
      .kill_o      (kill),
      .abort_o     (abort_o),
      .busy_o      (busy),
      .tag_o       (done_tag_o)
   );

   scsi_byte_hs #(.LEN_W(LEN_W)) u_hs (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .len_i   (len),
      .kill_i  (kill),
      .ack_i   (ack_s),
      .req_o   (hs_req),
      .take_o  (take),
      .ptr_o   (ptr_o),
      .done_o  (done_o)
   );

   assign lines   = ph_lines(ph);
   assign msg_o   = lines[2];
   assign cd_o    = lines[1];
   assign io_o    = lines[0];
   assign bsy_o   = (ph != PH_IDLE);
   assign req_o   = hs_req;
   assign db_oe_o = io_o;
   assign db_o    = io_o ? tx_byte_i : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q     <= '0;
         rx_stb_q <= 1'b0;
      end else begin
         rx_stb_q <= take && !io_o;
         if (take && !io_o) rx_q <= db_i;
      end
   end

   assign rx_byte_o = rx_q;
   assign rx_stb_o  = rx_stb_q;

   p_req_in_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (bsy_o && busy));

   p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (!bsy_o && !req_o && !msg_o && !cd_o && !io_o));

   p_oe_follows_io_r11: assert property (@(posedge clk) disable iff (!rst_n)
      db_oe_o |-> (io_o && bsy_o));

   p_rx_only_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb_o |-> !$past(io_o));

endmodule

// File: tb/scsi_tgt_phase_seq_tb.sv
module scsi_tgt_phase_seq_tb;

   localparam int LEN_W = 16;
   localparam int TAG_W = 4;

   typedef struct packed {
      logic [2:0] code;
      logic [7:0] len;
      logic [3:0] tag;
      logic       sel;
      logic       acc;
      logic [2:0] enc;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{3'd2, 8'd2, 4'd1,  1'b0, 1'b0, 3'b000},
      '{3'd0, 8'd6, 4'd2,  1'b0, 1'b0, 3'b000},
      '{3'd0, 8'd6, 4'd3,  1'b1, 1'b1, 3'b010},
      '{3'd4, 8'd1, 4'd4,  1'b0, 1'b0, 3'b010},
      '{3'd2, 8'd3, 4'd5,  1'b0, 1'b1, 3'b001},
      '{3'd1, 8'd2, 4'd6,  1'b0, 1'b0, 3'b001},
      '{3'd3, 8'd1, 4'd7,  1'b0, 1'b1, 3'b011},
      '{3'd4, 8'd1, 4'd8,  1'b0, 1'b1, 3'b110},
      '{3'd5, 8'd0, 4'd0,  1'b0, 1'b1, 3'b000},
      '{3'd0, 8'd6, 4'd9,  1'b1, 1'b1, 3'b010},
      '{3'd1, 8'd4, 4'd10, 1'b0, 1'b1, 3'b000},
      '{3'd3, 8'd0, 4'd11, 1'b0, 1'b1, 3'b011},
      '{3'd4, 8'd2, 4'd12, 1'b0, 1'b1, 3'b110},
      '{3'd5, 8'd0, 4'd0,  1'b0, 1'b1, 3'b000}
   };

   logic             clk = 1'b0, rst_n = 1'b0;
   logic             sel = 1'b0, rq_vld = 1'b0;
   logic [2:0]       rq_code = '0;
   logic [LEN_W-1:0] rq_len = '0;
   logic [TAG_W-1:0] rq_tag = '0;
   logic [2:0]       fault = '0;
   logic             ack_en = 1'b1;
   logic [1:0]       ack_sh = '0;
   logic             ack;
   logic [7:0]       db_in = 8'hC3, tx_b = 8'h3C;
   logic             bsy, msg, cd, io, req, db_oe, rx_stb, done, abort_p;
   logic [7:0]       db_out, rx_b;
   logic [LEN_W-1:0] ptr;
   logic [TAG_W-1:0] dtag;
   logic [2:0]       bus_ph;

   int n_chk = 0, n_bad = 0;
   int req_rises = 0, rx_cnt = 0, viol = 0;
   logic req_prev = 1'b0, ack_prev = 1'b0;
   logic [LEN_W-1:0] ptr_prev = '0;

   always #4 clk = ~clk;

   assign ack    = ack_en & ack_sh[1];
   assign bus_ph = {msg, cd, io} ^ fault;

   scsi_tgt_phase_seq #(.LEN_W(LEN_W), .TAG_W(TAG_W), .ACK_SYNC(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .rq_vld_i(rq_vld),
      .rq_code_i(rq_code), .rq_len_i(rq_len), .rq_tag_i(rq_tag),
      .bus_msg_i(bus_ph[2]), .bus_cd_i(bus_ph[1]), .bus_io_i(bus_ph[0]),
      .ack_i(ack), .db_i(db_in), .tx_byte_i(tx_b),
      .bsy_o(bsy), .msg_o(msg), .cd_o(cd), .io_o(io), .req_o(req),
      .db_o(db_out), .db_oe_o(db_oe), .rx_byte_o(rx_b), .rx_stb_o(rx_stb),
      .ptr_o(ptr), .done_o(done), .done_tag_o(dtag), .abort_o(abort_p)
   );

   // initiator model: ACK follows REQ two half-cycle samples later
   always @(negedge clk) begin
      ack_sh <= {ack_sh[0], req};
   end

   always @(posedge clk) begin
      req_prev <= req;
      ack_prev <= ack;
      ptr_prev <= ptr;
      if (req && !req_prev) begin
         req_rises <= req_rises + 1;
         if (ack) viol <= viol + 1;           // R6: REQ must not rise with ACK high
      end
      if (rx_stb) rx_cnt <= rx_cnt + 1;
      if (ptr != ptr_prev && ptr != '0 && ack_prev) viol <= viol + 1; // R6
   end

   task automatic chk(input bit ok, input string rid, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rid, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic issue(input logic [2:0] c, input int l, input int t, input logic s);
      @(negedge clk);
      rq_code = c; rq_len = LEN_W'(l); rq_tag = TAG_W'(t); sel = s; rq_vld = 1'b1;
      @(negedge clk);
      rq_vld = 1'b0; sel = 1'b0;
   endtask

   task automatic wait_done(output bit got);
      got = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         if (done) begin got = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
   end

   initial begin
      bit got;
      int rq0, rx0;
      logic [3:0] prev;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({bsy, req, msg, cd, io, db_oe, done, abort_p, rx_stb} == '0, "R1 outputs",
          int'({bsy, req, msg, cd, io, db_oe, done, abort_p, rx_stb}), 0);
      chk(ptr == '0, "R1 ptr", int'(ptr), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         prev = {bsy, msg, cd, io};
         rq0  = req_rises;
         rx0  = rx_cnt;
         issue(VEC[v].code, int'(VEC[v].len), int'(VEC[v].tag), VEC[v].sel);
         if (!VEC[v].acc) begin
            chk({bsy, msg, cd, io} == prev, (VEC[v].code == 3'd0 || prev[3] == 1'b0) ? "R2 reject" : "R4 reject",
                int'({bsy, msg, cd, io}), int'(prev));
            chk(!done, "R4 no done", int'(done), 0);
         end else if (VEC[v].code == 3'd5) begin
            chk({bsy, msg, cd, io} == 4'b0000, "R12 release", int'({bsy, msg, cd, io}), 0);
         end else begin
            chk({bsy, msg, cd, io} == {1'b1, VEC[v].enc}, "R3 lines",
                int'({bsy, msg, cd, io}), int'({1'b1, VEC[v].enc}));
            chk(db_oe == io && (!io || db_out == tx_b), "R11 drive", int'({db_oe, db_out}), int'({io, tx_b}));
            if (VEC[v].len == '0)
               chk(done && !req, "R8 zero length", int'({done, req}), 2);
            else
               chk(ptr == '0, "R9 ptr at entry", int'(ptr), 0);
            wait_done(got);
            chk(got, "R7 done seen", int'(got), 1);
            chk(dtag == VEC[v].tag, "R7 tag", int'(dtag), int'(VEC[v].tag));
            chk(ptr == LEN_W'(VEC[v].len), "R7 ptr", int'(ptr), int'(VEC[v].len));
            chk(req_rises - rq0 == int'(VEC[v].len), "R6 req count", req_rises - rq0, int'(VEC[v].len));
            if (!VEC[v].enc[0]) begin
               chk(rx_cnt - rx0 == int'(VEC[v].len), "R11 rx count", rx_cnt - rx0, int'(VEC[v].len));
               if (VEC[v].len != '0) chk(rx_b == db_in, "R11 rx byte", int'(rx_b), int'(db_in));
            end
            @(negedge clk);
            chk(!done && !req && {msg, cd, io} == VEC[v].enc, "R7 hold",
                int'({done, req, msg, cd, io}), int'(VEC[v].enc));
         end
      end

      // R5 and R10: busy command phase ignores requests and phase faults
      ack_en = 1'b0;
      issue(3'd0, 3, 13, 1'b1);
      chk({msg, cd, io} == 3'b010, "R3 cmd", int'({msg, cd, io}), 2);
      fault = 3'b001;
      repeat (3) @(negedge clk);
      chk(bsy && !abort_p && {msg, cd, io} == 3'b010, "R10 cmd ignores mismatch",
          int'({bsy, abort_p, msg, cd, io}), 5'b10010);
      fault = 3'b000;
      issue(3'd3, 0, 14, 1'b0);
      chk({msg, cd, io} == 3'b010 && !done, "R5 busy ignores", int'({msg, cd, io}), 2);
      ack_en = 1'b1;
      wait_done(got);
      chk(got && dtag == 4'd13, "R7 tag after busy", int'(dtag), 13);

      // R10 abort mid transfer
      ack_en = 1'b0;
      issue(3'd2, 4, 15, 1'b0);
      chk(req && {msg, cd, io} == 3'b001, "R6 req up", int'({req, msg, cd, io}), 9);
      fault = 3'b100;
      @(negedge clk);
      chk(abort_p && !bsy && !req && {msg, cd, io} == 3'b000 && !db_oe, "R10 abort",
          int'({abort_p, bsy, req, msg, cd, io, db_oe}), 64);
      fault = 3'b000;
      @(negedge clk);
      chk(!abort_p && ptr == '0, "R10 abort pulse", int'({abort_p, ptr}), 0);
      ack_en = 1'b1;
      repeat (6) @(negedge clk);

      // R10 abort from a completed status phase
      issue(3'd0, 1, 1, 1'b1);
      wait_done(got);
      issue(3'd3, 0, 2, 1'b0);
      wait_done(got);
      @(negedge clk);
      chk(bsy && {msg, cd, io} == 3'b011, "R7 status hold", int'({bsy, msg, cd, io}), 11);
      fault = 3'b010;
      @(negedge clk);
      chk(abort_p && !bsy, "R10 abort in hold", int'({abort_p, bsy}), 2);
      fault = 3'b000;
      @(negedge clk);

      chk(viol == 0, "R6 ordering", viol, 0);
      summary();
   end

endmodule